// File: doc/BRIEF.md
# Hex-Digit Left Normalizer with Guard Digit

This block takes an unnormalized base-16 floating-point result and brings its fraction into normal form. The result can come from an adder or a subtractor that has cancelled leading digits. A request gives a sign, a 7-bit biased exponent, a 24-bit fraction and one 4-bit guard digit that holds the first digit below the fraction. While the top hex digit of the fraction is zero, the block shifts the fraction left by one whole digit per clock and lowers the exponent by one. On the first shift the guard digit moves into the low digit. Any later shift fills the low digit with zero.

When the fraction is normal, the block packs sign, exponent and fraction into a 32-bit word and pulses `done`. If a shift is still needed when the exponent is already zero, it pulses `underflow` and clears the word. An all-zero fraction bypasses the loop and completes at once with an all-zero word.

Top module: `hexnorm_unit`

## Requirements
- R1: When the fraction's top digit (bits 23..20) is nonzero at entry, the word equals the input sign, exponent and fraction unchanged, and `done` is high after edge 1, where edge 0 is the rising edge that samples `in_valid`.
- R2: Word layout: bit 31 is the sign, bits 30..24 the exponent and bits 23..0 the fraction.
- R3: The first left shift moves the fraction up four bits, places the guard digit in bits 3..0 and lowers the exponent by one.
- R4: Every shift after the first places zero in bits 3..0, and each shift lowers the exponent by exactly one.
- R5: With n shifts, `done` is high for one cycle after edge n+1 and `busy` is high from edge 0 until then.
- R6: A nonzero fraction needs at most five shifts, so `busy` never stays high more than six cycles in a row.
- R7: An all-zero fraction gives an all-zero word with `done` high after edge 0, whatever the sign, exponent and guard digit.
- R8: If a shift is needed while the exponent is 0, `underflow` pulses for one cycle instead of `done` and the word becomes zero. A normal fraction with exponent 0 completes normally. `done` and `underflow` are never high together.
- R9: After reset, `done`, `underflow` and `busy` are low and the word is zero.
- R10: `in_valid` is ignored while `busy` is high. It does not change the result or the timing of the request in progress.
- R11: A request presented in the cycle where `done` is high is accepted at the next edge.
- R12: The word holds its value from one completion to the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request strobe, sampled when idle |
| in_sign | input | 1 | Sign of the value |
| in_exp | input | 7 | Biased exponent |
| in_frac | input | 24 | Unnormalized fraction |
| in_guard | input | 4 | Guard digit below the fraction |
| busy | output | 1 | Normalization in progress |
| done | output | 1 | One-cycle pulse, result word valid |
| underflow | output | 1 | One-cycle pulse, exponent exhausted |
| result | output | 32 | Packed sign, exponent and fraction |

## Verification
Two events can fall in the same cycle: completion of one request and acceptance of the next. The bench provokes this by raising `in_valid` in the very cycle that `done` is seen. It then checks three things: the old word stays visible while the new request is busy, the new request takes its expected number of cycles, and it yields its own packed word. Exponent exhaustion and the first guard-digit shift are made to meet on consecutive cycles, and `underflow` must then replace `done` rather than appear beside it.

// File: rtl/hexnorm_pkg.sv
package hexnorm_pkg;
  localparam int DIG_W = 4;
  typedef enum logic [0:0] {ST_IDLE = 1'b0, ST_NORM = 1'b1} norm_st_e;
endpackage

// File: rtl/hexnorm_lead.sv
// Per-digit nonzero flags; reports a zero top digit and an all-zero fraction.
module hexnorm_lead #(
  parameter int FRAC_W = 24
) (
  input  logic [FRAC_W-1:0] frac,
  output logic              top_zero,
  output logic              all_zero
);
  localparam int NDIG = FRAC_W / hexnorm_pkg::DIG_W;
  logic [NDIG-1:0] dig_nz;

  for (genvar d = 0; d < NDIG; d++) begin : g_dig
    assign dig_nz[d] = |frac[d*hexnorm_pkg::DIG_W +: hexnorm_pkg::DIG_W];
  end

  assign top_zero = ~dig_nz[NDIG-1];
  assign all_zero = ~|dig_nz;
endmodule

// File: rtl/hexnorm_shift.sv
// One-digit left shift; the low digit takes the guard or zero once it is spent.
module hexnorm_shift #(
  parameter int FRAC_W = 24
) (
  input  logic [FRAC_W-1:0]              frac,
  input  logic [hexnorm_pkg::DIG_W-1:0]  guard,
  input  logic                           guard_spent,
  output logic [FRAC_W-1:0]              shifted
);
  localparam int DW = hexnorm_pkg::DIG_W;
  logic [DW-1:0] fill;

  assign fill    = guard_spent ? '0 : guard;
  assign shifted = {frac[FRAC_W-DW-1:0], fill};
endmodule

// File: rtl/hexnorm_unit.sv
module hexnorm_unit #(
  parameter int FRAC_W = 24,
  parameter int EXP_W  = 7
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          in_valid,
  input  logic                          in_sign,
  input  logic [EXP_W-1:0]              in_exp,
  input  logic [FRAC_W-1:0]             in_frac,
  input  logic [hexnorm_pkg::DIG_W-1:0] in_guard,
  output logic                          busy,
  output logic                          done,
  output logic                          underflow,
  output logic [FRAC_W+EXP_W:0]         result
);
  import hexnorm_pkg::*;
  localparam int WORD_W = FRAC_W + EXP_W + 1;

  // reset: asynchronous assertion, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  norm_st_e            st_q, st_d;
  logic [FRAC_W-1:0]   frac_q, frac_d;
  logic [EXP_W-1:0]    exp_q, exp_d;
  logic                sign_q, sign_d;
  logic [DIG_W-1:0]    guard_q, guard_d;
  logic                spent_q, spent_d;
  logic                done_q, done_d;
  logic                unf_q, unf_d;
  logic [WORD_W-1:0]   res_q, res_d;
  logic                load_en, step_en;

  logic              in_top_zero, in_all_zero;
  logic              cur_top_zero, cur_all_zero;
  logic [FRAC_W-1:0] frac_shifted;

  hexnorm_lead #(.FRAC_W(FRAC_W)) u_lead_in (
    .frac(in_frac), .top_zero(in_top_zero), .all_zero(in_all_zero)
  );
  hexnorm_lead #(.FRAC_W(FRAC_W)) u_lead_cur (
    .frac(frac_q), .top_zero(cur_top_zero), .all_zero(cur_all_zero)
  );
  hexnorm_shift #(.FRAC_W(FRAC_W)) u_shift (
    .frac(frac_q), .guard(guard_q), .guard_spent(spent_q), .shifted(frac_shifted)
  );

  // next-state logic
  always_comb begin
    st_d    = st_q;
    frac_d  = frac_q;
    exp_d   = exp_q;
    sign_d  = sign_q;
    guard_d = guard_q;
    spent_d = spent_q;
    done_d  = 1'b0;
    unf_d   = 1'b0;
    res_d   = res_q;
    load_en = 1'b0;
    step_en = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (in_valid) begin
          if (in_all_zero) begin
            done_d = 1'b1;
            res_d  = '0;
          end else begin
            load_en = 1'b1;
            st_d    = ST_NORM;
          end
        end
      end
      ST_NORM: begin
        if (!cur_top_zero) begin
          done_d = 1'b1;
          res_d  = {sign_q, exp_q, frac_q};
          st_d   = ST_IDLE;
        end else if (exp_q == '0) begin
          unf_d = 1'b1;
          res_d = '0;
          st_d  = ST_IDLE;
        end else begin
          step_en = 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
    if (load_en) begin
      frac_d  = in_frac;
      exp_d   = in_exp;
      sign_d  = in_sign;
      guard_d = in_guard;
      spent_d = 1'b0;
    end
    if (step_en) begin
      frac_d  = frac_shifted;
      exp_d   = exp_q - EXP_W'(1);
      spent_d = 1'b1;
    end
  end

  // control and result registers
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      st_q   <= ST_IDLE;
      done_q <= 1'b0;
      unf_q  <= 1'b0;
      res_q  <= '0;
    end else begin
      st_q   <= st_d;
      done_q <= done_d;
      unf_q  <= unf_d;
      res_q  <= res_d;
    end
  end

  // datapath registers, enabled only on load or step
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      frac_q  <= '0;
      exp_q   <= '0;
      sign_q  <= 1'b0;
      guard_q <= '0;
      spent_q <= 1'b0;
    end else if (load_en || step_en) begin
      frac_q  <= frac_d;
      exp_q   <= exp_d;
      sign_q  <= sign_d;
      guard_q <= guard_d;
      spent_q <= spent_d;
    end
  end

  logic unused_ok;
  assign unused_ok = cur_all_zero | in_top_zero;

  assign busy      = (st_q == ST_NORM);
  assign done      = done_q;
  assign underflow = unf_q;
  assign result    = res_q;
endmodule

// File: rtl/hexnorm_chk.sv
module hexnorm_chk #(
  parameter int FRAC_W = 24,
  parameter int EXP_W  = 7
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  busy,
  input logic                  done,
  input logic                  underflow,
  input logic [FRAC_W+EXP_W:0] result
);
  localparam int MAX_BUSY = FRAC_W / hexnorm_pkg::DIG_W;
  logic [7:0] busy_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    busy_run <= '0;
    else if (busy) busy_run <= busy_run + 8'd1;
    else           busy_run <= '0;
  end

  AST_DONE_UNF_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && underflow)); // R8
  AST_UNF_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    underflow |=> !underflow); // R8
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(result) |-> (done || underflow)); // R12
  AST_NORM_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    (done && result != '0) |-> (result[FRAC_W-1 -: hexnorm_pkg::DIG_W] != '0)); // R1
  AST_BUSY_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    busy_run <= 8'(MAX_BUSY)); // R6
endmodule

bind hexnorm_unit hexnorm_chk #(.FRAC_W(FRAC_W), .EXP_W(EXP_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done),
  .underflow(underflow), .result(result)
);

// File: tb/tb_hexnorm_unit.sv
module tb_hexnorm_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic        in_sign;
  logic [6:0]  in_exp;
  logic [23:0] in_frac;
  logic [3:0]  in_guard;
  logic        busy, done, underflow;
  logic [31:0] result;

  int n_chk = 0;
  int n_fail = 0;

  hexnorm_unit dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sign(in_sign),
    .in_exp(in_exp), .in_frac(in_frac), .in_guard(in_guard),
    .busy(busy), .done(done), .underflow(underflow), .result(result)
  );

  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic v, input logic s, input logic [6:0] e,
                       input logic [23:0] f, input logic [3:0] g);
    in_valid = v; in_sign = s; in_exp = e; in_frac = f; in_guard = g;
  endtask

  // waits (at negedges) for done or underflow; returns the latency in cycles
  task automatic wait_end(input bit junk, output int lat);
    lat = 0;
    forever begin
      @(negedge clk);
      lat++;
      if (done || underflow || lat > 20) begin
        in_valid = 1'b0;
        break;
      end
      if (junk) drive(1'b1, 1'b0, 7'h7F, 24'h000000, 4'h0);
    end
  endtask

  task automatic run_case(input logic s, input logic [6:0] e, input logic [23:0] f,
                          input logic [3:0] g, input logic [31:0] exp_res,
                          input bit exp_unf, input int exp_lat, input string tag,
                          input bit junk);
    int lat;
    @(negedge clk);
    drive(1'b1, s, e, f, g);
    wait_end(junk, lat);
    chk(lat == exp_lat, {tag, " latency"}, 32'(lat), 32'(exp_lat));
    chk(underflow == exp_unf && done == !exp_unf, {tag, " flag"},
        {30'd0, done, underflow}, {30'd0, !exp_unf, exp_unf});
    chk(result == exp_res, {tag, " result"}, result, exp_res);
    @(negedge clk);
    chk(!done && !underflow, {tag, " pulse width"}, {30'd0, done, underflow}, 32'd0);
  endtask

  task automatic t_reset();
    chk(!done && !underflow && !busy && result == 32'd0, "R9 reset state",
        result, 32'd0);
  endtask

  task automatic t_back_to_back();
    int lat;
    @(negedge clk);
    drive(1'b1, 1'b0, 7'h22, 24'h9ABCDE, 4'h1);
    wait_end(1'b0, lat);
    chk(done && result == 32'h229ABCDE, "R11 first done", result, 32'h229ABCDE);
    drive(1'b1, 1'b1, 7'h05, 24'h0ABCDE, 4'h3);   // offered in the done cycle
    @(negedge clk);
    in_valid = 1'b0;
    chk(busy, "R11 accepted in done cycle", {31'd0, busy}, 32'd1);
    chk(result == 32'h229ABCDE, "R12 result held while busy", result, 32'h229ABCDE);
    wait_end(1'b0, lat);
    chk(lat == 2, "R11 second latency", 32'(lat), 32'd2);
    chk(done && result == 32'h84ABCDE3, "R11 second result", result, 32'h84ABCDE3);
  endtask

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 50000) begin
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
      end
    end
  end

  initial begin
    drive(1'b0, 1'b0, 7'h00, 24'h0, 4'h0);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    // R1 R2: already normal
    run_case(1'b1, 7'h41, 24'hA12345, 4'h7, 32'hC1A12345, 1'b0, 2, "R1 R2 normal", 1'b0);
    // R3: one shift pulls guard in
    run_case(1'b0, 7'h40, 24'h0FFFFF, 4'hE, 32'h3FFFFFFE, 1'b0, 3, "R3 guard shift", 1'b0);
    // R4 R5: four shifts, zeros after guard
    run_case(1'b0, 7'h40, 24'h000056, 4'h9, 32'h3C569000, 1'b0, 6, "R4 R5 multi shift", 1'b0);
    // R6: worst case five shifts
    run_case(1'b1, 7'h10, 24'h000001, 4'h0, 32'h8B100000, 1'b0, 7, "R6 max shift", 1'b0);
    // R7: zero bypass
    run_case(1'b1, 7'h55, 24'h000000, 4'hF, 32'h00000000, 1'b0, 1, "R7 zero", 1'b0);
    // R8: underflow after one shift, at entry, and normal with exponent 0
    run_case(1'b0, 7'h01, 24'h000123, 4'h4, 32'h00000000, 1'b1, 3, "R8 underflow late", 1'b0);
    run_case(1'b1, 7'h00, 24'h0ABCDE, 4'h4, 32'h00000000, 1'b1, 2, "R8 underflow entry", 1'b0);
    run_case(1'b0, 7'h00, 24'h800000, 4'h4, 32'h00800000, 1'b0, 2, "R8 exp zero normal", 1'b0);
    // R10: requests while busy are ignored
    run_case(1'b0, 7'h40, 24'h000056, 4'h9, 32'h3C569000, 1'b0, 6, "R10 ignore busy", 1'b1);
    t_back_to_back();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule